// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing Generator

This block produces the serial clock and the chip-select lines of a serial flash controller. It works from the reference clock and takes two 32-bit words. The configuration word carries enable, clock polarity, clock phase, a 4-bit baud divisor, a 4-bit select field and a decode-mode bit. The delay word carries four 8-bit counts in reference cycles: select setup before the first clock, hold after the last clock, a gap before switching to another device, and the minimum deselect time.

A sequencer asks for a transfer with a start pulse and ends it with a stop pulse. The block asserts select, waits out the setup count, and then toggles the serial clock in whole periods. After a stop it finishes the period in progress and releases select after the hold time. It then keeps select high for at least the deselect time. Each clock edge is announced one reference cycle ahead by a sample strobe and a shift strobe, and an idle flag shows when the block can accept a new start. Both the hold and the deselect time include fixed extra cycles on top of the programmed counts.

Top module: `spi_sclk_cs_gen`

## Requirements
- R1: After reset, idle is 1, cs_n is 4'hF and sclk is 0.
- R2: Each serial-clock half period lasts div+1 reference cycles, where div is cfg_word[22:19]. Every transfer holds a whole, non-zero number of clock periods, so the count of edges is even.
- R3: sclk rests at the polarity bit cfg_word[1] whenever select is released. With phase bit cfg_word[2]=0, sample_stb is high in the cycle just before each leading edge (the edge away from the rest level) and shift_stb is high before each trailing edge. With phase bit 1 the two strobes swap.
- R4: The first sclk edge comes dly_word[7:0] + div + 2 reference cycles after cs_n goes active.
- R5: cs_n returns to 4'hF dly_word[15:8] + 2*(div+1) + 3 cycles after the last sclk edge.
- R6: Between two transfers, cs_n stays 4'hF for at least dly_word[31:24] + 2*(div+1) + 1 cycles. A start that is held high across this time is taken exactly when that time has passed.
- R7: A start that comes while idle activates select on the next cycle. When the select code differs from the code of the previous transfer, activation waits a further dly_word[23:16] cycles.
- R8: With decode bit cfg_word[9]=0, cfg_word[11:10] gives the device number n, and while a transfer is active cs_n has bit n low and all other bits high.
- R9: With decode bit 1, cs_n carries cfg_word[13:10] unchanged while a transfer is active.
- R10: Polarity, phase, divisor, select field and decode bit are captured when enable (cfg_word[0]) rises. Changes made while enable is held at 1 have no effect.
- R11: idle is 1 only when no transfer, hold, deselect or device gap is in progress.
- R12: With enable at 0, start is ignored. Clearing enable during a transfer releases select and returns sclk to its rest level on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Configuration: enable, polarity, phase, decode, select field, divisor |
| dly_word | input | 32 | Four 8-bit timing counts in reference cycles |
| xfer_start | input | 1 | Request to begin a transfer |
| xfer_stop | input | 1 | Request to end the transfer after the current clock period |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Chip-select lines, active low |
| sample_stb | output | 1 | High in the cycle before an edge on which input data is captured |
| shift_stb | output | 1 | High in the cycle before an edge on which output data changes |
| idle | output | 1 | Block is idle and accepts a start |

## Verification
The bench sweeps all four divisor values that fit a short run against all four polarity and phase combinations. For each pair it uses a different set of setup, hold and deselect counts. Every edge interval, the first-edge delay and the last-edge-to-release delay are measured against the arithmetic forms above, so an off-by-one in any counter shows up as a wrong interval rather than a wrong level. Back-to-back transfers with start held high separate the deselect minimum from the start latency. Changes of device number and a decode-mode code separate the device gap from the normal one-cycle start. Field changes made while enabled, and a disable during a transfer, show whether configuration is latched only on the enable edge.

// File: rtl/spi_sclk_cs_gen.sv
`timescale 1ns/1ps
module spi_sclk_cs_gen #(
  parameter int DIVW = 4,
  parameter int CSW  = 4,
  parameter int DLYW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_word,
  input  logic [31:0] dly_word,
  input  logic        xfer_start,
  input  logic        xfer_stop,
  output logic        sclk,
  output logic [3:0]  cs_n,
  output logic        sample_stb,
  output logic        shift_stb,
  output logic        idle
);
  localparam int CNTW = DLYW + DIVW + 3;
  localparam int NSW  = (CSW > 1) ? $clog2(CSW) : 1;

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_SETUP, S_RUN, S_HOLD, S_DESEL} st_t;
  st_t state;

  logic            en_q, cpol_q, cpha_q, dec_q, ph, stop_pend, last_vld;
  logic [DIVW-1:0] div_q, hc;
  logic [CSW-1:0]  csf_q, last_cs;
  logic [CNTW-1:0] cnt;

  wire en = cfg_word[0];
  wire [DLYW-1:0] t_slch = dly_word[7:0];
  wire [DLYW-1:0] t_chsh = dly_word[15:8];
  wire [DLYW-1:0] t_sd2d = dly_word[23:16];
  wire [DLYW-1:0] t_shsl = dly_word[31:24];

  wire [CNTW-1:0] per    = (CNTW'(div_q) + CNTW'(1)) << 1;
  wire [CSW-1:0]  cs_sel = dec_q ? csf_q : ~(CSW'(1) << csf_q[NSW-1:0]);
  wire cs_act   = (state == S_SETUP) || (state == S_RUN) || (state == S_HOLD);
  wire edge_now = (state == S_RUN) && (hc == '0);
  wire lead     = edge_now && !ph;
  wire trail    = edge_now && ph;
  wire need_gap = last_vld && (last_cs != cs_sel) && (t_sd2d != '0);

  assign sclk       = cpol_q ^ ph;
  assign cs_n       = cs_act ? cs_sel : '1;
  assign sample_stb = cpha_q ? trail : lead;
  assign shift_stb  = cpha_q ? lead : trail;
  assign idle       = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; dec_q <= 1'b0;
      div_q <= '0; csf_q <= '1;
    end else begin
      en_q <= en;
      if (en && !en_q) begin
        cpol_q <= cfg_word[1];
        cpha_q <= cfg_word[2];
        dec_q  <= cfg_word[9];
        csf_q  <= cfg_word[13:10];
        div_q  <= cfg_word[22:19];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; hc <= '0; ph <= 1'b0;
      stop_pend <= 1'b0; last_vld <= 1'b0; last_cs <= '1;
    end else if (!en) begin
      state <= S_IDLE; ph <= 1'b0; stop_pend <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (xfer_start && en_q) begin
            last_cs   <= cs_sel;
            last_vld  <= 1'b1;
            stop_pend <= 1'b0;
            if (need_gap) begin
              state <= S_GAP;   cnt <= CNTW'(t_sd2d) - CNTW'(1);
            end else begin
              state <= S_SETUP; cnt <= CNTW'(t_slch);
            end
          end
        S_GAP:
          if (cnt == '0) begin state <= S_SETUP; cnt <= CNTW'(t_slch); end
          else cnt <= cnt - CNTW'(1);
        S_SETUP: begin
          if (xfer_stop) stop_pend <= 1'b1;
          if (cnt == '0) begin state <= S_RUN; hc <= div_q; end
          else cnt <= cnt - CNTW'(1);
        end
        S_RUN: begin
          if (xfer_stop) stop_pend <= 1'b1;
          if (hc == '0) begin
            hc <= div_q;
            ph <= ~ph;
            if (ph && (stop_pend || xfer_stop)) begin
              state <= S_HOLD;
              cnt   <= CNTW'(t_chsh) + per + CNTW'(2);
            end
          end else hc <= hc - 1'b1;
        end
        S_HOLD:
          if (cnt == '0) begin state <= S_DESEL; cnt <= CNTW'(t_shsl) + per - CNTW'(1); end
          else cnt <= cnt - CNTW'(1);
        S_DESEL:
          if (cnt == '0) state <= S_IDLE;
          else cnt <= cnt - CNTW'(1);
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r8_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 4'hF && !dec_q) |-> $countones(cs_n) == 3);
  a_r3_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 4'hF) |-> sclk == cpol_q);
  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> cs_n == 4'hF);
  a_r10_cs_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 4'hF && $past(cs_n) != 4'hF) |-> $stable(cs_n));
  a_r2_edge_announced: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 4'hF && $past(cs_n) != 4'hF && !$stable(sclk)) |-> $past(sample_stb || shift_stb));
endmodule

// File: tb/spi_sclk_cs_gen_tb_top.sv
`timescale 1ns/1ps
module spi_sclk_cs_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_word = '0, dly_word = '0;
  logic xfer_start = 1'b0, xfer_stop = 1'b0;
  logic sclk, sample_stb, shift_stb, idle;
  logic [3:0] cs_n;

  spi_sclk_cs_gen dut_i (.clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .dly_word(dly_word),
    .xfer_start(xfer_start), .xfer_stop(xfer_stop), .sclk(sclk), .cs_n(cs_n),
    .sample_stb(sample_stb), .shift_stb(shift_stb), .idle(idle));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  int exp_H = 1, exp_tslch = 0, exp_tchsh = 0, exp_tshsl = 0, exp_tsd2d = 0, exp_lat = 1;
  logic exp_cpol = 0, exp_cpha = 0;
  logic [3:0] exp_cs = 4'hF, last_code = 4'hF;
  bit last_valid = 0, mon_abort = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  logic m_act = 0, m_sclk = 0, m_samp = 0, m_first = 0;
  int t_csl = 0, t_edge = 0, m_edges = 0;
  always @(negedge clk) if (rst_n) begin
    automatic bit act = (cs_n != 4'hF);
    if (act && !m_act) begin
      t_csl = cyc; m_first = 1; m_edges = 0;
      check(cs_n == exp_cs, exp_cs[0] ^ exp_cs[1] ^ exp_cs[2] ^ exp_cs[3] ? "R8 cs code" : "R9 cs code",
            cs_n, exp_cs);
    end
    if (act && m_act && sclk != m_sclk) begin
      automatic bit leading = (sclk != exp_cpol);
      if (m_first) check(cyc - t_csl == exp_tslch + exp_H + 1, "R4 first edge", cyc - t_csl, exp_tslch + exp_H + 1);
      else         check(cyc - t_edge == exp_H, "R2 half period", cyc - t_edge, exp_H);
      check(m_samp == (leading ? !exp_cpha : exp_cpha), "R3 sample strobe", m_samp, leading ? !exp_cpha : exp_cpha);
      t_edge = cyc; m_first = 0; m_edges++;
    end
    if (!act && m_act && !mon_abort) begin
      check(cyc - t_edge == exp_tchsh + 2*exp_H + 3, "R5 hold", cyc - t_edge, exp_tchsh + 2*exp_H + 3);
      check(m_edges > 0 && m_edges % 2 == 0, "R2 whole periods", m_edges, 2);
      check(sclk == exp_cpol, "R3 rest level", sclk, exp_cpol);
    end
    m_act = act; m_sclk = sclk; m_samp = sample_stb;
  end

  function automatic logic [31:0] mkcfg(bit en, bit cpol, bit cpha, int dv, bit dec, logic [3:0] csf);
    logic [31:0] w = '0;
    w[0] = en; w[1] = cpol; w[2] = cpha; w[9] = dec; w[13:10] = csf; w[22:19] = 4'(dv);
    return w;
  endfunction

  task automatic wait_act(input bit want);
    int n = 0;
    while (((cs_n != 4'hF) != want) && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!idle && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic setup_cfg(bit cpol, bit cpha, int dv, bit dec, logic [3:0] csf);
    @(negedge clk); cfg_word = mkcfg(0, cpol, cpha, dv, dec, csf);
    @(negedge clk); cfg_word[0] = 1'b1;
    exp_cpol = cpol; exp_cpha = cpha; exp_H = dv + 1;
    exp_cs = dec ? csf : ~(4'b1 << csf[1:0]);
    exp_lat = (last_valid && exp_cs != last_code && exp_tsd2d != 0) ? 1 + exp_tsd2d : 1;
    last_code = exp_cs; last_valid = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_dly(int slch, int chsh, int sd2d, int shsl);
    dly_word = {8'(shsl), 8'(sd2d), 8'(chsh), 8'(slch)};
    exp_tslch = slch; exp_tchsh = chsh; exp_tsd2d = sd2d; exp_tshsl = shsl;
  endtask

  task automatic do_xfer(int run);
    int c0;
    xfer_start = 1; c0 = cyc;
    @(negedge clk); xfer_start = 0;
    wait_act(1);
    check(cyc - c0 == exp_lat, "R7 start latency", cyc - c0, exp_lat);
    repeat (run) @(negedge clk);
    check(idle == 0, "R11 busy flag", idle, 0);
    xfer_stop = 1; @(negedge clk); xfer_stop = 0;
    wait_act(0);
    check(idle == 0, "R11 busy during deselect", idle, 0);
    wait_idle();
    check(idle == 1, "R11 idle after", idle, 1);
  endtask

  task automatic do_pair(int run);
    int t;
    xfer_start = 1;
    wait_act(1);
    repeat (run) @(negedge clk);
    xfer_stop = 1; @(negedge clk); xfer_stop = 0;
    wait_act(0); t = cyc;
    wait_act(1);
    check(cyc - t == exp_tshsl + 2*exp_H + 1, "R6 deselect", cyc - t, exp_tshsl + 2*exp_H + 1);
    xfer_start = 0;
    repeat (run) @(negedge clk);
    xfer_stop = 1; @(negedge clk); xfer_stop = 0;
    wait_act(0); wait_idle();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(idle == 1, "R1 idle", idle, 1);
    check(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
    check(sclk == 0, "R1 sclk", sclk, 0);
    rst_n = 1;
    @(negedge clk);
    xfer_start = 1; @(negedge clk); xfer_start = 0;
    repeat (3) @(negedge clk);
    check(cs_n == 4'hF && idle, "R12 start ignored when disabled", cs_n, 4'hF);

    for (int d = 0; d < 4; d++) begin
      for (int m = 0; m < 4; m++) begin
        set_dly(d, m, 3, (d + m) % 3);
        setup_cfg(m[1], m[0], d, 0, 4'((d + m) % 4));
        do_xfer(2*(d+1) + 3 + m);
        exp_lat = 1;
        do_pair(d + 1 + m);
      end
    end

    set_dly(2, 1, 5, 1);
    setup_cfg(0, 1, 1, 1, 4'b0110);
    do_xfer(7);
    exp_lat = 1;
    do_xfer(4);

    setup_cfg(1, 0, 2, 0, 4'd3);
    @(negedge clk); cfg_word = mkcfg(1, 0, 1, 0, 1, 4'b1001);
    do_xfer(9);

    mon_abort = 1;
    xfer_start = 1; @(negedge clk); xfer_start = 0;
    wait_act(1);
    repeat (exp_tslch + 4) @(negedge clk);
    cfg_word[0] = 1'b0;
    @(negedge clk);
    check(cs_n == 4'hF, "R12 abort cs_n", cs_n, 4'hF);
    check(sclk == exp_cpol, "R12 abort sclk", sclk, exp_cpol);
    check(idle == 1, "R12 abort idle", idle, 1);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule